// File: doc/BRIEF.md
# Branch Direction Predictor with Target Buffer

This block predicts the direction and destination of conditional branches for a fetch stage that reads four instructions per cycle as one aligned 16-byte group. It holds a small direct-mapped table. Each entry keeps a valid flag, an address tag, a 32-bit destination and a 2-bit saturating confidence counter. The fetch stage presents the group PC on the lookup port. In the same cycle it gets back a hit flag, a taken prediction and the address to fetch next. Every instruction of one fetch group maps to the same entry.

The branch unit resolves each branch in a single cycle and reports the outcome on the update port: the branch PC, whether it was taken, and its computed destination. A matching entry has its counter stepped and its destination rewritten. A non-matching entry is claimed for the new branch: its tag and destination are written, and the outcome is applied to a counter that starts from weakly taken. Updates are registered, so a lookup in the same cycle still sees the old contents.

Top module: `bpred_btb`

## Requirements
- R1: After reset every entry is invalid and every counter holds weakly taken (2'b10), so every lookup misses.
- R2: The entry index is PC bits 7:4 and the tag is PC bits 31:8. PC bits 3:0 are ignored, so the four instructions of a group share one entry.
- R3: A lookup that misses (entry invalid or tag differs) gives hit=0, taken=0 and target=PC+4.
- R4: A lookup that hits gives hit=1 and taken equal to the counter's upper bit. The target is the stored destination when taken and PC+4 otherwise.
- R5: An update whose PC misses allocates the entry. It writes the tag and destination and sets the counter to weakly taken stepped by the outcome: taken gives 2'b11, not-taken gives 2'b01.
- R6: The counter uses the encoding 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. It moves up on taken and down on not-taken, and it saturates at 00 and 11.
- R7: An update whose PC hits steps the counter and overwrites the stored destination with the reported one.
- R8: A lookup and an update in the same cycle return the contents from before the update. The update is visible to lookups from the next cycle on.
- R9: An update with a different tag at an occupied index replaces that entry. The previous branch then misses, and the new one starts from weakly taken.
- R10: While the update valid input is low, the update PC, outcome and destination inputs change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | 32 | Fetch group PC to look up |
| lk_hit | output | 1 | Valid entry with matching tag |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | 32 | Predicted next fetch address |
| up_valid | input | 1 | Update strobe from the branch unit |
| up_pc | input | 32 | PC of the resolved branch |
| up_taken | input | 1 | Resolved direction |
| up_target | input | 32 | Resolved destination |

## Verification
Lookup results are combinational, so they are due in the same cycle the PC is presented. The bench samples them one time unit after driving the PC, away from any edge. An update lands on the next rising edge and is first visible to a lookup made after that edge. The bench therefore drives each update just after a falling edge, waits for the rising edge, and checks only after the following falling edge. The same-cycle case is checked on both sides of that edge. Counter states that do not show in the taken flag are brought out by applying further updates and watching the cycle in which the prediction flips.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_t;

  // saturating step of the confidence counter
  function automatic ctr_t ctr_step(ctr_t c, logic taken);
    case (c)
      CTR_SNT: return taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: return taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  return taken ? CTR_ST  : CTR_WNT;
      default: return taken ? CTR_ST  : CTR_WT;
    endcase
  endfunction

  function automatic logic ctr_predicts(ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/bp_entry.sv
module bp_entry
  import bpred_pkg::*;
#(
  parameter int unsigned TAG_W  = 24,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_alloc,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_target,
  input  logic              wr_taken,
  output logic              ent_valid,
  output logic [TAG_W-1:0]  ent_tag,
  output logic [ADDR_W-1:0] ent_target,
  output ctr_t              ent_ctr
);

  ctr_t base_ctr;
  assign base_ctr = wr_alloc ? CTR_WT : ent_ctr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid  <= 1'b0;
      ent_tag    <= '0;
      ent_target <= '0;
      ent_ctr    <= CTR_WT;
    end else if (wr_en) begin
      ent_valid  <= 1'b1;
      ent_tag    <= wr_tag;
      ent_target <= wr_target;
      ent_ctr    <= ctr_step(base_ctr, wr_taken);
    end
  end

endmodule

// File: rtl/bp_tag_match.sv
module bp_tag_match #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned TAG_W   = 24
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [TAG_W-1:0]   tag_arr [ENTRIES],
  input  logic [IDX_W-1:0]   idx,
  input  logic [TAG_W-1:0]   tag_in,
  output logic               hit
);

  assign hit = valid_vec[idx] && (tag_arr[idx] == tag_in);

endmodule

// File: rtl/bpred_btb.sv
module bpred_btb
  import bpred_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned ENTRIES    = 16,
  parameter int unsigned FETCH_W    = 4,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic              lk_taken,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic              up_taken,
  input  logic [ADDR_W-1:0] up_target
);

  localparam int unsigned IDX_LO = $clog2(FETCH_W * INSN_BYTES);
  localparam int unsigned IDX_W  = $clog2(ENTRIES);
  localparam int unsigned TAG_LO = IDX_LO + IDX_W;
  localparam int unsigned TAG_W  = ADDR_W - TAG_LO;
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << IDX_LO) - 1);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(INSN_BYTES);

  function automatic logic [IDX_W-1:0] idx_of(logic [ADDR_W-1:0] a);
    return a[TAG_LO-1:IDX_LO];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:TAG_LO];
  endfunction

  function automatic logic [ADDR_W-1:0] seq_next(logic [ADDR_W-1:0] a);
    return a + STEP;
  endfunction

  // entry storage
  logic [ENTRIES-1:0] ent_valid;
  logic [TAG_W-1:0]   ent_tag    [ENTRIES];
  logic [ADDR_W-1:0]  ent_target [ENTRIES];
  ctr_t               ent_ctr    [ENTRIES];

  // update-side decode, brought out as named wires
  logic [ADDR_W-1:0] upd_grp;
  logic [IDX_W-1:0]  upd_idx;
  logic [TAG_W-1:0]  upd_tag;
  logic              upd_hit;
  logic              upd_alloc;

  assign upd_grp   = up_pc & ~LOW_MASK;
  assign upd_idx   = idx_of(upd_grp);
  assign upd_tag   = tag_of(upd_grp);
  assign upd_alloc = up_valid && !upd_hit;

  bp_tag_match #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_upd_match (
    .valid_vec(ent_valid),
    .tag_arr  (ent_tag),
    .idx      (upd_idx),
    .tag_in   (upd_tag),
    .hit      (upd_hit)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = up_valid && (upd_idx == IDX_W'(g));
    bp_entry #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (sel),
      .wr_alloc  (!upd_hit),
      .wr_tag    (upd_tag),
      .wr_target (up_target),
      .wr_taken  (up_taken),
      .ent_valid (ent_valid[g]),
      .ent_tag   (ent_tag[g]),
      .ent_target(ent_target[g]),
      .ent_ctr   (ent_ctr[g])
    );
  end

  // lookup side
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic             lk_match;
  ctr_t             lk_ctr;

  assign lk_idx = idx_of(lk_pc);
  assign lk_tag = tag_of(lk_pc);

  bp_tag_match #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_lk_match (
    .valid_vec(ent_valid),
    .tag_arr  (ent_tag),
    .idx      (lk_idx),
    .tag_in   (lk_tag),
    .hit      (lk_match)
  );

  assign lk_ctr    = ent_ctr[lk_idx];
  assign lk_hit    = lk_match;
  assign lk_taken  = lk_match && ctr_predicts(lk_ctr);
  assign lk_target = lk_taken ? ent_target[lk_idx] : seq_next(lk_pc);

endmodule

// File: rtl/bpred_btb_chk.sv
module bpred_btb_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] lk_pc,
  input logic              lk_hit,
  input logic              lk_taken,
  input logic [ADDR_W-1:0] lk_target,
  input logic              up_valid,
  input logic [ADDR_W-1:0] up_pc,
  input logic              up_taken,
  input logic [ADDR_W-1:0] up_target,
  input logic              upd_hit
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  // R3
  miss_falls_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (!lk_taken && lk_target == lk_pc + STEP));

  // R8
  update_seen_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(up_valid) && lk_pc == $past(up_pc)) |-> lk_hit);

  // R5
  alloc_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(up_valid && !upd_hit && up_taken) && lk_pc == $past(up_pc))
      |-> (lk_taken && lk_target == $past(up_target)));

  // R5
  alloc_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(up_valid && !upd_hit && !up_taken) && lk_pc == $past(up_pc))
      |-> !lk_taken);

  // R10
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!up_valid) && $stable(lk_pc))
      |-> ($stable(lk_hit) && $stable(lk_taken) && $stable(lk_target)));

endmodule

bind bpred_btb bpred_btb_chk #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_pc    (lk_pc),
  .lk_hit   (lk_hit),
  .lk_taken (lk_taken),
  .lk_target(lk_target),
  .up_valid (up_valid),
  .up_pc    (up_pc),
  .up_taken (up_taken),
  .up_target(up_target),
  .upd_hit  (upd_hit)
);

// File: tb/bpred_btb_bench.sv
module bpred_btb_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_hit;
  logic        lk_taken;
  logic [31:0] lk_target;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;
  logic [31:0] up_target = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bpred_btb u_bpred_btb (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // present a PC and compare the combinational result
  task automatic look(string req, logic [31:0] pc, logic eh, logic et, logic [31:0] tgt);
    lk_pc = pc;
    #1;
    chk(req, "hit", {31'b0, lk_hit}, {31'b0, eh});
    chk(req, "taken", {31'b0, lk_taken}, {31'b0, et});
    chk(req, "target", lk_target, et ? tgt : pc + 32'd4);
  endtask

  // drive one update; returns just after the following falling edge
  task automatic upd(logic [31:0] pc, logic tk, logic [31:0] tgt);
    up_valid = 1'b1; up_pc = pc; up_taken = tk; up_target = tgt;
    @(posedge clk);
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  localparam logic [31:0] PA = 32'h0000_0130; // index 3, tag 1
  localparam logic [31:0] PB = 32'h0000_0040; // index 4, tag 0
  localparam logic [31:0] PC = 32'h0000_0050; // index 5
  localparam logic [31:0] PD = 32'h0000_0060; // index 6
  localparam logic [31:0] PE = 32'h0000_0230; // index 3, tag 2
  localparam logic [31:0] PF = 32'h0000_0070; // index 7

  task automatic t_reset();
    look("R1", PA, 1'b0, 1'b0, 32'h0);
    look("R3", 32'hFFFF_FFF0, 1'b0, 1'b0, 32'h0);
    look("R3", 32'h0000_0000, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_alloc();
    upd(PA, 1'b1, 32'h0000_1000);
    look("R5", PA, 1'b1, 1'b1, 32'h0000_1000);
    upd(PB, 1'b0, 32'h0000_2000);
    look("R4", PB, 1'b1, 1'b0, 32'h0);
    // weakly taken start: 10 -> taken 11 -> not-taken 10 still predicts taken (R1)
    upd(PA, 1'b0, 32'h0000_1000);
    look("R1", PA, 1'b1, 1'b1, 32'h0000_1000);
  endtask

  task automatic t_group();
    look("R2", PA + 32'd8, 1'b1, 1'b1, 32'h0000_1000);
    look("R2", PA + 32'd12, 1'b1, 1'b1, 32'h0000_1000);
    look("R2", PA + 32'd16, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_sat_high();
    upd(PC, 1'b1, 32'h0000_3000);
    for (int i = 0; i < 3; i++) upd(PC, 1'b1, 32'h0000_3300);
    look("R7", PC, 1'b1, 1'b1, 32'h0000_3300);
    upd(PC, 1'b0, 32'h0000_3300);
    look("R6", PC, 1'b1, 1'b1, 32'h0000_3300);
    upd(PC, 1'b0, 32'h0000_3300);
    look("R6", PC, 1'b1, 1'b0, 32'h0);
  endtask

  task automatic t_sat_low();
    upd(PD, 1'b0, 32'h0000_4000);
    for (int i = 0; i < 4; i++) upd(PD, 1'b0, 32'h0000_4000);
    upd(PD, 1'b1, 32'h0000_4400);
    look("R6", PD, 1'b1, 1'b0, 32'h0);
    upd(PD, 1'b1, 32'h0000_4400);
    look("R6", PD, 1'b1, 1'b1, 32'h0000_4400);
  endtask

  task automatic t_alias();
    upd(PE, 1'b0, 32'h0000_5000);
    look("R9", PE, 1'b1, 1'b0, 32'h0);
    look("R9", PA, 1'b0, 1'b0, 32'h0);
    upd(PE, 1'b1, 32'h0000_5500);
    look("R9", PE, 1'b1, 1'b1, 32'h0000_5500);
  endtask

  task automatic t_same_cycle();
    up_valid = 1'b1; up_pc = PF; up_taken = 1'b1; up_target = 32'h0000_6000;
    look("R8", PF, 1'b0, 1'b0, 32'h0);
    @(posedge clk);
    @(negedge clk);
    up_valid = 1'b0;
    look("R8", PF, 1'b1, 1'b1, 32'h0000_6000);
  endtask

  task automatic t_idle();
    up_valid = 1'b0; up_pc = PF; up_taken = 1'b0; up_target = 32'h0000_7777;
    repeat (3) @(posedge clk);
    @(negedge clk);
    look("R10", PF, 1'b1, 1'b1, 32'h0000_6000);
    up_pc = PA;
    repeat (2) @(posedge clk);
    @(negedge clk);
    look("R10", PA, 1'b0, 1'b0, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc();
    t_group();
    t_sat_high();
    t_sat_low();
    t_alias();
    t_same_cycle();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1..: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule